// File: doc/BRIEF.md
# Serial Audio Receive Queue with Interrupt Status

This block receives a two-channel serial audio stream and queues the samples for software. The bit clock and word-select line come from a neighbouring transmit interface, so the block generates no serial clocks. These serial inputs are resynchronised into the system clock domain. Serial data is taken on each rising bit-clock edge. A control bit chooses which of two data lines is used: the external pin or the analog front end.

A sample is emitted whenever the word-select line changes. Each sample is sign-extended and stored as one 32-bit word in a 16-entry queue. Software reads the queue through a small register window. The window also holds a control register, an interrupt-enable mask, live and masked status views, and a write-one-to-clear register for the two sticky error flags. A single level-sensitive interrupt is raised while any enabled status bit is set.

Top module: `i2s_rx_fifo`

## Requirements
- R1: After reset the raw status reads 0x20 (queue empty only), the control, mask and masked-status registers read 0, and `irq` is low.
- R2: With word select low selecting the left channel, samples are taken MSB first. Each sample starts one bit clock after a word-select change. The bit captured at a word-select change still belongs to the slot that is ending. When the slot ends, its first W bits are pushed, sign-extended to 32 bits. Capture starts at the first falling word-select edge after reset, so the first sample pushed is a left sample. From then on, left and right samples alternate.
- R3: Control bit 5 set selects 14-bit samples; clear selects 16-bit samples. Control bit 2 set selects the front-end data line `sd_fe`; clear selects `sd_pin`. The line that is not selected is ignored.
- R4: Raw status bits show the queue level live: bit 5 empty (0 entries), bit 3 at least 8 entries, bit 2 at least 12 entries, bit 1 full (16 entries).
- R5: A sample that arrives while the queue is full is discarded, and raw status bit 6 is set and stays set.
- R6: A read of offset 0x14 returns the oldest queued sample and removes it. A read of 0x14 while the queue is empty returns 0 and sets raw status bit 0, which stays set.
- R7: Writing offset 0x10 clears raw status bit 6 and/or bit 0 where the written bit is 1. Ones written to the level bits have no effect.
- R8: Offset 0x0C reads raw status ANDed with the mask at offset 0x04 (bits 6:0). `irq` is high exactly when that result is nonzero.
- R9: Control (0x00) reads back only bits 5 and 2. The mask reads back only bits 6:0. Offset 0x18 reads 0. Writes to the status and data offsets are ignored. Read data appears on the cycle after the read request.
- R10: A slot that ends before W bits have been captured is discarded without setting any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access request this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the request |
| ser_bclk | input | 1 | Bit clock from the transmit interface |
| ser_ws | input | 1 | Word select (0 = left) |
| sd_pin | input | 1 | Serial data from the external pin |
| sd_fe | input | 1 | Serial data from the analog front end |
| irq | output | 1 | Level interrupt, any enabled status bit set |

## Verification
A wrong queue count shows up in the raw status read that directly follows the sample push or data read that caused it. For this reason the bench reads the level flags after every sample pair and after every single drain read, over the whole range from empty to full. A broken shift counter or slot boundary corrupts the sign bit or the sample order. That appears at the first data read after the stream ends. A sticky bit that leaks or fails to clear shows up on `irq` one cycle after the clear write.

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int DEPTH    = 16,
  parameter int SLOT_W   = 16,
  parameter int NARROW_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ser_bclk,
  input  logic        ser_ws,
  input  logic        sd_pin,
  input  logic        sd_fe,
  output logic        irq
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int PW     = $clog2(DEPTH);
  localparam int BW     = $clog2(SLOT_W + 1);
  localparam int HALF   = DEPTH / 2;
  localparam int ALMOST = DEPTH - DEPTH / 4;

  localparam logic [2:0] W_CTRL = 3'd0, W_MASK = 3'd1, W_RAW = 3'd2,
                         W_PEND = 3'd3, W_ACK  = 3'd4, W_DATA = 3'd5;

  logic [1:0] bclk_s, ws_s, pin_s, fe_s;
  logic       bclk_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_s <= '0; ws_s <= 2'b11; pin_s <= '0; fe_s <= '0; bclk_d <= 1'b0;
    end else begin
      bclk_s <= {bclk_s[0], ser_bclk};
      ws_s   <= {ws_s[0], ser_ws};
      pin_s  <= {pin_s[0], sd_pin};
      fe_s   <= {fe_s[0], sd_fe};
      bclk_d <= bclk_s[1];
    end
  end

  logic       cfg_narrow, cfg_fe;
  logic [6:0] mask;
  logic       push_err, pop_err;

  wire rise   = bclk_s[1] & ~bclk_d;
  wire ws_bit = ws_s[1];
  wire sd_bit = cfg_fe ? fe_s[1] : pin_s[1];

  logic              ws_q, armed;
  logic [BW-1:0]     bit_cnt;
  logic [SLOT_W-1:0] shreg;

  wire [BW-1:0]     need   = cfg_narrow ? BW'(NARROW_W) : BW'(SLOT_W);
  wire              take   = bit_cnt < need;
  wire [SLOT_W-1:0] sr_nx  = take ? {shreg[SLOT_W-2:0], sd_bit} : shreg;
  wire [BW-1:0]     cnt_nx = take ? bit_cnt + BW'(1) : bit_cnt;
  wire              ws_chg = rise & (ws_bit != ws_q);
  wire              push_req = ws_chg & armed & (cnt_nx == need);

  logic [31:0] sample;
  always_comb begin
    if (cfg_narrow)
      sample = {{(32-NARROW_W){sr_nx[NARROW_W-1]}}, sr_nx[NARROW_W-1:0]};
    else
      sample = {{(32-SLOT_W){sr_nx[SLOT_W-1]}}, sr_nx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q <= 1'b1; armed <= 1'b0; bit_cnt <= '0; shreg <= '0;
    end else if (rise) begin
      ws_q <= ws_bit;
      if (ws_bit != ws_q) begin
        bit_cnt <= '0;
        shreg   <= '0;
        if (!ws_bit) armed <= 1'b1;
      end else begin
        bit_cnt <= cnt_nx;
        shreg   <= sr_nx;
      end
    end
  end

  wire [2:0] word   = reg_addr[4:2];
  wire       rd_req = reg_sel & ~reg_we;
  wire       wr_req = reg_sel & reg_we;
  wire       pop_req = rd_req & (word == W_DATA);
  wire       ack_wr  = wr_req & (word == W_ACK);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  wire empty  = count == '0;
  wire full   = count == CW'(DEPTH);
  wire half   = count >= CW'(HALF);
  wire almost = count >= CW'(ALMOST);
  wire push_ok = push_req & ~full;
  wire pop_ok  = pop_req & ~empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (pop_ok)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  wire [6:0] raw  = {push_err, empty, 1'b0, half, almost, full, pop_err};
  wire [6:0] pend = raw & mask;
  assign irq = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_err <= 1'b0; pop_err <= 1'b0;
      cfg_narrow <= 1'b0; cfg_fe <= 1'b0; mask <= '0;
    end else begin
      push_err <= (push_req & full)  | (push_err & ~(ack_wr & reg_wdata[6]));
      pop_err  <= (pop_req  & empty) | (pop_err  & ~(ack_wr & reg_wdata[0]));
      if (wr_req && word == W_CTRL) begin
        cfg_narrow <= reg_wdata[5];
        cfg_fe     <= reg_wdata[2];
      end
      if (wr_req && word == W_MASK) mask <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (rd_req) begin
      case (word)
        W_CTRL:  reg_rdata <= {26'd0, cfg_narrow, 2'b00, cfg_fe, 2'b00};
        W_MASK:  reg_rdata <= {25'd0, mask};
        W_RAW:   reg_rdata <= {25'd0, raw};
        W_PEND:  reg_rdata <= {25'd0, pend};
        W_DATA:  reg_rdata <= empty ? 32'd0 : mem[rp];
        default: reg_rdata <= 32'd0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:7]};

  assert_drop_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> push_err);
  assert_empty_read_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (pop_err && reg_rdata == 32'd0));
  assert_flag_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (almost && half && !empty));
  assert_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !push_req |=> count <= $past(count));
  assert_sticky_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_err && !(ack_wr && reg_wdata[6])) |=> push_err);
  assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 7'd0) |-> !irq);
  assert_push_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !push_req);
endmodule

// File: tb/i2s_rx_fifo_tb.sv
module i2s_rx_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ser_bclk = 0, ser_ws = 1, sd_pin = 0, sd_fe = 0, irq;

  always #2.5 clk = ~clk;

  i2s_rx_fifo dut_i (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_bclk(ser_bclk), .ser_ws(ser_ws), .sd_pin(sd_pin), .sd_fe(sd_fe), .irq(irq));

  int tests = 0, fails = 0;
  bit done = 0;
  bit use_fe = 0, narrow = 0, inv = 0, pend_bit = 0, perr = 0;
  logic [31:0] q[$];
  logic [31:0] rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_we = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_sel = 0; d = reg_rdata;
  endtask

  task automatic ser_bit(input bit w, input bit b);
    @(negedge clk); ser_ws = w;
    sd_pin = use_fe ? ~b : b;
    sd_fe  = use_fe ? b : ~b;
    repeat (4) @(negedge clk); ser_bclk = 1;
    repeat (4) @(negedge clk); ser_bclk = 0;
  endtask

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
    ser_bit(0, pend_bit);
    for (int i = 15; i >= 1; i--) ser_bit(0, l[i]);
    ser_bit(1, l[0]);
    for (int i = 15; i >= 1; i--) ser_bit(1, r[i]);
    pend_bit = r[0];
  endtask

  function automatic logic [15:0] val(input int i);
    return 16'(i * 16'h1357 + 16'h8421);
  endfunction

  function automatic logic [31:0] cv(input logic [15:0] v0);
    logic [15:0] v = inv ? ~v0 : v0;
    return narrow ? {{18{v[15]}}, v[15:2]} : {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] raw_exp(input int n, input bit pe, input bit oe);
    return {25'd0, pe, n == 0, 1'b0, n >= 8, n >= 12, n == 16, oe};
  endfunction

  task automatic model_push(input logic [31:0] x);
    if (q.size() == 16) perr = 1; else q.push_back(x);
  endtask

  task automatic stream(input int n, input int base);
    logic [15:0] pr = 0;
    for (int i = 0; i < n; i++) begin
      send_pair(val(base + 2*i), val(base + 2*i + 1));
      if (i > 0) model_push(cv(pr));
      model_push(cv(val(base + 2*i)));
      pr = val(base + 2*i + 1);
      bus_rd(5'h08, rd); chk("R4/R5 level flags during fill", rd, raw_exp(q.size(), perr, 0));
    end
    ser_bit(0, pend_bit);
    model_push(cv(pr));
    ser_bit(1, 0); ser_bit(1, 0);
    bus_rd(5'h08, rd); chk("R10 short slots dropped, status", rd, raw_exp(q.size(), perr, 0));
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin
      logic [31:0] e = q.pop_front();
      bus_rd(5'h14, rd); chk(tag, rd, e);
      bus_rd(5'h08, rd); chk("R4 level flags during drain", rd, raw_exp(q.size(), perr, 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    bus_rd(5'h08, rd); chk("R1 raw status after reset", rd, 32'h20);
    bus_rd(5'h00, rd); chk("R1 control after reset", rd, 0);
    bus_rd(5'h04, rd); chk("R1 mask after reset", rd, 0);
    bus_rd(5'h0C, rd); chk("R1 masked status after reset", rd, 0);
    chk("R1 irq after reset", irq, 0);

    bus_wr(5'h00, 32'hFFFF_FFFF); bus_rd(5'h00, rd); chk("R9 control readback", rd, 32'h24);
    bus_wr(5'h00, 0);
    bus_wr(5'h04, 32'hFFFF_FFFF); bus_rd(5'h04, rd); chk("R9 mask readback", rd, 32'h7F);
    bus_wr(5'h04, 0);
    bus_rd(5'h18, rd); chk("R9 spare offset reads zero", rd, 0);
    bus_wr(5'h08, 32'hFF); bus_wr(5'h14, 32'h1234);
    bus_rd(5'h08, rd); chk("R9 status/data writes ignored", rd, 32'h20);

    ser_bit(1, 0); ser_bit(1, 0);
    stream(9, 0);
    chk("R5 push error after overflow", perr, 1);
    bus_wr(5'h04, 32'h40); chk("R8 irq on push error", irq, 1);
    bus_rd(5'h0C, rd); chk("R8 masked status", rd, 32'h40);
    bus_wr(5'h10, 32'h3E);
    bus_rd(5'h08, rd); chk("R7 level bits unaffected by clear", rd, raw_exp(16, 1, 0));
    drain("R2/R6 16-bit sample order");
    bus_wr(5'h10, 32'h40); perr = 0;
    bus_rd(5'h08, rd); chk("R7 push error cleared", rd, 32'h20);
    chk("R8 irq drops after clear", irq, 0);

    bus_rd(5'h14, rd); chk("R6 empty read returns zero", rd, 0);
    bus_rd(5'h08, rd); chk("R6 pop error set", rd, 32'h21);
    bus_wr(5'h04, 32'h01); chk("R8 irq on pop error", irq, 1);
    bus_wr(5'h10, 32'h01);
    bus_rd(5'h08, rd); chk("R7 pop error cleared", rd, 32'h20);
    chk("R8 irq low after pop clear", irq, 0);
    bus_wr(5'h04, 32'h20); chk("R8 irq from empty flag", irq, 1);
    bus_wr(5'h04, 0);

    narrow = 1; use_fe = 1; inv = 0;
    bus_wr(5'h00, 32'h24);
    stream(3, 40); drain("R3 14-bit front-end source");
    use_fe = 1; inv = 1;
    bus_wr(5'h00, 32'h20);
    stream(3, 60); drain("R3 pin source ignores front end");
    narrow = 0; use_fe = 0; inv = 1;
    bus_wr(5'h00, 32'h04);
    stream(2, 80); drain("R3 16-bit front-end ignores pin");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule